// File: doc/BRIEF.md
# Three-Bank Selectable Clock Divider

This block takes a fast source clock and produces eleven output clocks in three banks. A bypass pin chooses the source. When the pin is high the source is a reference clock. When it is low the source is an on-chip oscillator clock. A shared stage can halve the source rate ahead of every bank. Each bank then divides by one of two even ratios, chosen by its own static select pin. The ratio pairs differ from bank to bank, and so does the select polarity.

One active-high pin does two jobs: it holds the block and it disables the outputs. While it is high, every divider is cleared, every output sits low and each bank's output-enable is low, so the pad ring leaves that bank floating. While the pin is high, the block also captures the bank selects and the halving select. When the pin drops, all banks make their first rising edge on the same source edge. Banks at related ratios therefore stay rising-edge aligned. Every output has a 50% duty cycle, and this includes the divide-by-6 ratio.

Top module: `clk_bank_divider`

## Requirements
- R1: Bank A (five identical outputs) divides the stage output by 4 when `sel_a` is 0 and by 6 when it is 1.
- R2: Bank B (four identical outputs) divides the stage output by 4 when `sel_b` is 0 and by 2 when it is 1.
- R3: Bank C (two identical outputs) divides the stage output by 2 when `sel_c` is 0 and by 4 when it is 1.
- R4: When `src_half` is 1, the source is divided by two ahead of all banks, so every bank period doubles. When it is 0, the source passes unchanged.
- R5: When `ref_bypass` is 1, the source is `ref_clk`. When it is 0, the source is `osc_clk`.
- R6: On the first source rising edge that samples `halt_hiz` high, and on every later edge while it stays high, all outputs go low and all three output-enables go low.
- R7: On the first source rising edge that samples `halt_hiz` low after a hold, all three output-enables go high and every output of every bank rises on that same edge.
- R8: Every output is high for exactly half of its period, for every ratio.
- R9: `sel_a`, `sel_b`, `sel_c` and `src_half` are captured only while `halt_hiz` is high. Changes to them while the block runs leave every output period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock source |
| ref_clk | input | 1 | Reference clock source |
| ref_bypass | input | 1 | 1 selects ref_clk, 0 selects osc_clk |
| src_half | input | 1 | 1 halves the source ahead of the banks |
| sel_a | input | 1 | Bank A ratio select (0: /4, 1: /6) |
| sel_b | input | 1 | Bank B ratio select (0: /4, 1: /2) |
| sel_c | input | 1 | Bank C ratio select (0: /2, 1: /4) |
| halt_hiz | input | 1 | Active-high hold and output disable |
| bank_a | output | 5 | Bank A clocks |
| bank_a_oe | output | 1 | Bank A output enable |
| bank_b | output | 4 | Bank B clocks |
| bank_b_oe | output | 1 | Bank B output enable |
| bank_c | output | 2 | Bank C clocks |
| bank_c_oe | output | 1 | Bank C output enable |

## Verification
The bench builds the block with its default parameters: five, four and two outputs, and ratio pairs 4/6, 4/2 and 2/4. With these values it can run all eight select combinations in both source modes, with the halving stage on and off. The ratios then range from 2 to 12 source cycles, so periods of up to 240 ns are measured within a short run. A 20 ns reference clock and a 10 ns oscillator clock make each source choice show up in the measured periods.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

    // Prescaler state: captured halving select and alternating phase
    typedef struct packed {
        logic half_sel;
        logic phase;
    } pre_st_t;

    // Largest of two integers, used to size counters
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cdiv_prescale.sv
`timescale 1ns/1ps
module cdiv_prescale
    import cdiv_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  logic half_i,
    output logic tick_o
);

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.half_sel = half_i;
            st_d.phase    = 1'b1;   // first running edge is a tick
        end else begin
            st_d.phase    = ~st_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick_o = ~st_q.half_sel | st_q.phase;

endmodule

// File: rtl/cdiv_bank.sv
`timescale 1ns/1ps
module cdiv_bank
    import cdiv_pkg::*;
#(
    parameter int N_OUT    = 2,
    parameter int RATIO_LO = 2,
    parameter int RATIO_HI = 4
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             tick,
    input  logic             sel_i,
    output logic             sel_o,
    output logic [N_OUT-1:0] clk_o
);

    localparam int HALF_LO  = RATIO_LO / 2;
    localparam int HALF_HI  = RATIO_HI / 2;
    localparam int HALF_MAX = max2(HALF_LO, HALF_HI);
    localparam int CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
    localparam logic [CW-1:0] LAST_LO = CW'(HALF_LO - 1);
    localparam logic [CW-1:0] LAST_HI = CW'(HALF_HI - 1);

    typedef struct packed {
        logic          sel;
        logic [CW-1:0] cnt;
        logic          q;
    } bank_st_t;

    bank_st_t      st_d, st_q;
    logic [CW-1:0] last_w;

    always_comb begin
        st_d   = st_q;
        last_w = st_q.sel ? LAST_HI : LAST_LO;
        if (clear) begin
            // preload so the first tick after release toggles high
            st_d.sel = sel_i;
            st_d.cnt = sel_i ? LAST_HI : LAST_LO;
            st_d.q   = 1'b0;
        end else if (tick) begin
            if (st_q.cnt == last_w) begin
                st_d.cnt = '0;
                st_d.q   = ~st_q.q;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel_o = st_q.sel;

    for (genvar i = 0; i < N_OUT; i++) begin : g_fan
        assign clk_o[i] = st_q.q;
    end

endmodule

// File: rtl/clk_bank_divider.sv
`timescale 1ns/1ps
module clk_bank_divider #(
    parameter int A_COUNT = 5,
    parameter int B_COUNT = 4,
    parameter int C_COUNT = 2,
    parameter int A_LO    = 4,
    parameter int A_HI    = 6,
    parameter int B_LO    = 4,
    parameter int B_HI    = 2,
    parameter int C_LO    = 2,
    parameter int C_HI    = 4
) (
    input  logic               osc_clk,
    input  logic               ref_clk,
    input  logic               ref_bypass,
    input  logic               src_half,
    input  logic               sel_a,
    input  logic               sel_b,
    input  logic               sel_c,
    input  logic               halt_hiz,
    output logic [A_COUNT-1:0] bank_a,
    output logic               bank_a_oe,
    output logic [B_COUNT-1:0] bank_b,
    output logic               bank_b_oe,
    output logic [C_COUNT-1:0] bank_c,
    output logic               bank_c_oe
);

    typedef struct packed {
        logic drive;
    } ctl_st_t;

    logic    src_clk;
    logic    pre_tick;
    logic    a_sel_q, b_sel_q, c_sel_q;
    ctl_st_t ctl_d, ctl_q;

    assign src_clk = ref_bypass ? ref_clk : osc_clk;

    cdiv_prescale u_pre (
        .clk    (src_clk),
        .clear  (halt_hiz),
        .half_i (src_half),
        .tick_o (pre_tick)
    );

    cdiv_bank #(.N_OUT(A_COUNT), .RATIO_LO(A_LO), .RATIO_HI(A_HI)) u_bank_a (
        .clk   (src_clk),
        .clear (halt_hiz),
        .tick  (pre_tick),
        .sel_i (sel_a),
        .sel_o (a_sel_q),
        .clk_o (bank_a)
    );

    cdiv_bank #(.N_OUT(B_COUNT), .RATIO_LO(B_LO), .RATIO_HI(B_HI)) u_bank_b (
        .clk   (src_clk),
        .clear (halt_hiz),
        .tick  (pre_tick),
        .sel_i (sel_b),
        .sel_o (b_sel_q),
        .clk_o (bank_b)
    );

    cdiv_bank #(.N_OUT(C_COUNT), .RATIO_LO(C_LO), .RATIO_HI(C_HI)) u_bank_c (
        .clk   (src_clk),
        .clear (halt_hiz),
        .tick  (pre_tick),
        .sel_i (sel_c),
        .sel_o (c_sel_q),
        .clk_o (bank_c)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.drive = ~halt_hiz;
    end

    always_ff @(posedge src_clk) begin
        ctl_q <= ctl_d;
    end

    assign bank_a_oe = ctl_q.drive;
    assign bank_b_oe = ctl_q.drive;
    assign bank_c_oe = ctl_q.drive;

endmodule

// File: rtl/clk_bank_divider_chk.sv
`timescale 1ns/1ps
module clk_bank_divider_chk #(
    parameter int A_N = 5,
    parameter int B_N = 4,
    parameter int C_N = 2
) (
    input logic           src_clk,
    input logic           halt_hiz,
    input logic           tick,
    input logic           a_sel,
    input logic           b_sel,
    input logic           c_sel,
    input logic [A_N-1:0] bank_a,
    input logic           bank_a_oe,
    input logic [B_N-1:0] bank_b,
    input logic           bank_b_oe,
    input logic [C_N-1:0] bank_c,
    input logic           bank_c_oe
);

    // R6
    hold_quiet_chk: assert property (@(posedge src_clk)
        halt_hiz |=> (!bank_a_oe && !bank_b_oe && !bank_c_oe &&
                      bank_a == '0 && bank_b == '0 && bank_c == '0));

    // R7
    release_align_chk: assert property (@(posedge src_clk) disable iff (halt_hiz)
        !bank_a_oe |=> (bank_a_oe && bank_b_oe && bank_c_oe &&
                        bank_a[0] && bank_b[0] && bank_c[0]));

    // R4
    tick_gate_chk: assert property (@(posedge src_clk) disable iff (halt_hiz)
        (bank_a_oe && !tick) |=> ($stable(bank_a[0]) && $stable(bank_b[0]) && $stable(bank_c[0])));

    // R2
    b_fast_chk: assert property (@(posedge src_clk) disable iff (halt_hiz)
        (bank_b_oe && b_sel && tick) |=> (bank_b[0] != $past(bank_b[0])));

    // R3
    c_fast_chk: assert property (@(posedge src_clk) disable iff (halt_hiz)
        (bank_c_oe && !c_sel && tick) |=> (bank_c[0] != $past(bank_c[0])));

    // R9
    sel_hold_chk: assert property (@(posedge src_clk) disable iff (halt_hiz)
        bank_a_oe |=> $stable({a_sel, b_sel, c_sel}));

endmodule

bind clk_bank_divider clk_bank_divider_chk #(
    .A_N(A_COUNT), .B_N(B_COUNT), .C_N(C_COUNT)
) u_chk (
    .src_clk   (src_clk),
    .halt_hiz  (halt_hiz),
    .tick      (pre_tick),
    .a_sel     (a_sel_q),
    .b_sel     (b_sel_q),
    .c_sel     (c_sel_q),
    .bank_a    (bank_a),
    .bank_a_oe (bank_a_oe),
    .bank_b    (bank_b),
    .bank_b_oe (bank_b_oe),
    .bank_c    (bank_c),
    .bank_c_oe (bank_c_oe)
);

// File: tb/tb_clk_bank_divider.sv
`timescale 1ns/1ps
module tb_clk_bank_divider;

    logic osc_clk = 1'b0, ref_clk = 1'b0;
    logic ref_bypass = 1'b0, src_half = 1'b0;
    logic sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic halt_hiz = 1'b1;
    logic [4:0] bank_a;
    logic [3:0] bank_b;
    logic [1:0] bank_c;
    logic bank_a_oe, bank_b_oe, bank_c_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 ref_clk = ~ref_clk;   // 50 MHz reference
    always #5  osc_clk = ~osc_clk;   // 100 MHz oscillator

    clk_bank_divider dut (
        .osc_clk(osc_clk), .ref_clk(ref_clk), .ref_bypass(ref_bypass),
        .src_half(src_half), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .halt_hiz(halt_hiz),
        .bank_a(bank_a), .bank_a_oe(bank_a_oe),
        .bank_b(bank_b), .bank_b_oe(bank_b_oe),
        .bank_c(bank_c), .bank_c_oe(bank_c_oe)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_edge(input int b, input bit rise);
        case (b)
            0: if (rise) @(posedge bank_a[0]); else @(negedge bank_a[0]);
            1: if (rise) @(posedge bank_b[0]); else @(negedge bank_b[0]);
            default: if (rise) @(posedge bank_c[0]); else @(negedge bank_c[0]);
        endcase
    endtask

    // period and high time of one bank, checked against expectation (R8 for duty)
    task automatic measure(input int b, input string req, input longint exp_per);
        longint t0, t1, t2;
        wait_edge(b, 1'b1); t0 = longint'($time);
        wait_edge(b, 1'b0); t1 = longint'($time);
        wait_edge(b, 1'b1); t2 = longint'($time);
        check(t2 - t0 == exp_per, req, t2 - t0, exp_per);
        check(t1 - t0 == exp_per / 2, {"R8 duty ", req}, t1 - t0, exp_per / 2);
    endtask

    // One scenario: hold, program, release, measure. flip changes selects while running (R9).
    task automatic run_mode(input bit byp, input bit pre, input bit sa, input bit sb,
                            input bit sc, input bit flip);
        longint tsrc, k;
        string  tag;
        tsrc = byp ? 20 : 10;
        k    = pre ? 2 : 1;
        tag  = $sformatf("byp%0d pre%0d a%0d b%0d c%0d%s", byp, pre, sa, sb, sc,
                         flip ? " R9 flipped" : "");
        @(negedge ref_clk); #2;
        halt_hiz = 1'b1; ref_bypass = byp; src_half = pre;
        sel_a = sa; sel_b = sb; sel_c = sc;
        repeat (3) @(negedge ref_clk);
        #2;
        // R6: disabled and low while held
        check({bank_a_oe, bank_b_oe, bank_c_oe} == 3'b000, {"R6 oe ", tag},
              longint'({bank_a_oe, bank_b_oe, bank_c_oe}), 0);
        check({bank_a, bank_b, bank_c} == 11'h0, {"R6 out ", tag},
              longint'({bank_a, bank_b, bank_c}), 0);
        halt_hiz = 1'b0;
        // next source edge is 3 ns (osc) or 8 ns (ref) later; sample 1 ns after it
        if (byp) #9; else #4;
        // R7: enabled and all rising on the first edge
        check({bank_a_oe, bank_b_oe, bank_c_oe} == 3'b111, {"R7 oe ", tag},
              longint'({bank_a_oe, bank_b_oe, bank_c_oe}), 7);
        check({bank_a, bank_b, bank_c} == 11'h7ff, {"R7 out ", tag},
              longint'({bank_a, bank_b, bank_c}), 2047);
        if (flip) begin
            sel_a = ~sa; sel_b = ~sb; sel_c = ~sc; src_half = ~pre;
        end
        measure(0, {"R1 R4 R5 ", tag}, (sa ? 6 : 4) * k * tsrc);
        #1 check(bank_a == 5'h1f, {"R1 copies ", tag}, longint'(bank_a), 31);
        measure(1, {"R2 R4 R5 ", tag}, (sb ? 2 : 4) * k * tsrc);
        #1 check(bank_b == 4'hf, {"R2 copies ", tag}, longint'(bank_b), 15);
        measure(2, {"R3 R4 R5 ", tag}, (sc ? 4 : 2) * k * tsrc);
        #1 check(bank_c == 2'h3, {"R3 copies ", tag}, longint'(bank_c), 3);
    endtask

    task automatic run_all_modes();
        for (int m = 0; m < 32; m++) begin
            run_mode(m[4], m[3], m[2], m[1], m[0], 1'b0);
        end
    endtask

    task automatic run_select_hold();
        run_mode(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_mode(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge ref_clk);
        #2;
        // R6: state after the initial hold
        check({bank_a_oe, bank_b_oe, bank_c_oe} == 3'b000, "R6 initial oe",
              longint'({bank_a_oe, bank_b_oe, bank_c_oe}), 0);
        check({bank_a, bank_b, bank_c} == 11'h0, "R6 initial out",
              longint'({bank_a, bank_b, bank_c}), 0);
        run_all_modes();
        run_select_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule